// File: doc/BRIEF.md
# Calendar Counter Chain

This block keeps wall-clock time and date as a set of registered counters: seconds, minutes, hours, day of month, month, a two-digit year and a weekday. One system clock runs every counter, and a one-cycle enable `tick_i` marks each elapsed second. When a counter reaches its top value, it raises a one-cycle carry. That carry enables the next stage in the same cycle, so a full roll-over from the last second of a year to the first second of the next completes on a single tick.

The day counter works out the length of the current month from the month and year registers and publishes it on `mdays_o`. Adjustment logic uses this value to bound its edits. The weekday stage is enabled by the hour carry, in parallel with the day stage. Each field has its own active-low load strobe and preset value, so an adjuster can overwrite any field at any time. Counting then resumes from the loaded value.

Top module: `cal_chain`

## Requirements
- R1: Seconds and minutes each count 0..59. On a tick that finds seconds at 59, seconds return to 0 and minutes advance in the same cycle. Minutes at 59 likewise return to 0 and advance hours.
- R2: Hours count 0..23. A wrap from 23 to 0 advances both the day and the weekday on the same tick.
- R3: `mdays_o` depends on the current month and year, with months numbered from 1 = January:
  - February gives 29 when the year's two low bits are 00, and 28 otherwise.
  - Months 4, 6, 9 and 11 give 30.
  - Every other month value, including 0 and 13..15, gives 31.
- R4: The day counts 1..`mdays_o`. When an advance finds the day equal to `mdays_o`, the day returns to 1 and the month advances.
- R5: The month counts 1..12 and then returns to 1 while advancing the year. The year counts 0..99 and returns to 0, and nothing beyond it changes.
- R6: The weekday counts 1..7 and returns to 1. It steps on every hour wrap, independently of whether the day is loaded.
- R7: While bit k of `ld_n_i` is low, field k takes its preset value at that clock edge. The load overrides any advance of that field and blocks its carry. The next advance counts on from the preset. The bit order is 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday.
- R8: A seconds, minutes, hours, month, year or weekday value at or above that field's top value returns to its bottom value on its next advance. That advance also raises the field's carry.
- R9: On a tick that finds the day above `mdays_o`, the day is clamped to `mdays_o`, and the month does not advance.
- R10: Reset, synchronous and active high, gives 00:00:00, day 1, month 1, year 0, weekday 1.
- R11: In a cycle with no tick and no load, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable, once per second |
| ld_n_i | input | 7 | Active-low load strobes, one per field (bit order in R7) |
| sec_pre_i | input | 6 | Seconds preset |
| min_pre_i | input | 6 | Minutes preset |
| hour_pre_i | input | 5 | Hours preset |
| day_pre_i | input | 5 | Day preset |
| mon_pre_i | input | 4 | Month preset |
| year_pre_i | input | 7 | Year preset |
| wday_pre_i | input | 3 | Weekday preset |
| sec_o | output | 6 | Current seconds |
| min_o | output | 6 | Current minutes |
| hour_o | output | 5 | Current hours |
| day_o | output | 5 | Current day of month |
| mon_o | output | 4 | Current month |
| year_o | output | 7 | Current year |
| wday_o | output | 3 | Current weekday |
| mdays_o | output | 5 | Days in the current month |

## Verification
Month and year ends are hours, days or years of ticks away from reset. Reaching them by counting is out of reach, so the stimulus loads every field to one tick before the boundary and then applies a single tick. This covers the February ends of leap and non-leap years, the 30-day months, the wrap from year 99 to 0 and an out-of-range month of 13. The hardest case to reach is a load that collides with a carry in the same cycle. The bench drives a day load on the very tick that wraps the hour, and checks that the weekday still steps. Day clamping is reached by loading a day larger than the loaded month allows.

// File: rtl/cal_pkg.sv
package cal_pkg;
  // field widths
  localparam int SEC_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 7;
  localparam int WDAY_W = 3;

  // load strobe bit positions
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;
  localparam int NFIELD = 7;
endpackage

// File: rtl/cal_wrap_ctr.sv
module cal_wrap_ctr #(
  parameter int W  = 6,
  parameter int LO = 0,
  parameter int HI = 59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  input  logic         ld_n_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LO_V  = W'(LO);
  localparam logic [W-1:0] HI_V  = W'(HI);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top  = (cnt_q >= HI_V);
  assign carry_o = adv_i & ld_n_i & at_top;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= LO_V;
    else if (!ld_n_i) cnt_q <= preset_i;
    else if (adv_i)   cnt_q <= at_top ? LO_V : cnt_q + ONE_V;
  end

  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ld_n_i && adv_i && cnt_q >= HI_V) |=> cnt_q == LO_V); // R8
  AST_CTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ld_n_i |=> cnt_q == $past(preset_i)); // R7
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ld_n_i && !adv_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/cal_mdays.sv
module cal_mdays #(
  parameter int MON_W  = 4,
  parameter int YEAR_W = 7,
  parameter int DAY_W  = 5
) (
  input  logic [MON_W-1:0]  mon_i,
  input  logic [YEAR_W-1:0] year_i,
  output logic [DAY_W-1:0]  mdays_o
);
  logic leap;
  assign leap = (year_i[1:0] == 2'b00);

  always_comb begin
    case (mon_i)
      MON_W'(2):                                    mdays_o = leap ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11):  mdays_o = DAY_W'(30);
      default:                                      mdays_o = DAY_W'(31);
    endcase
  end
endmodule

// File: rtl/cal_day_ctr.sv
module cal_day_ctr #(
  parameter int DAY_W  = 5,
  parameter int MON_W  = 4,
  parameter int YEAR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              adv_i,
  input  logic              ld_n_i,
  input  logic [DAY_W-1:0]  preset_i,
  input  logic [MON_W-1:0]  mon_i,
  input  logic [YEAR_W-1:0] year_i,
  output logic [DAY_W-1:0]  day_o,
  output logic [DAY_W-1:0]  mdays_o,
  output logic              carry_o
);
  localparam logic [DAY_W-1:0] FIRST = DAY_W'(1);

  logic [DAY_W-1:0] day_q;
  logic [DAY_W-1:0] mdays;
  logic             over;

  cal_mdays #(.MON_W(MON_W), .YEAR_W(YEAR_W), .DAY_W(DAY_W)) u_len (
    .mon_i  (mon_i),
    .year_i (year_i),
    .mdays_o(mdays)
  );

  assign over    = (day_q > mdays);
  assign carry_o = adv_i & ld_n_i & (day_q == mdays);
  assign day_o   = day_q;
  assign mdays_o = mdays;

  always_ff @(posedge clk) begin
    if (rst)                 day_q <= FIRST;
    else if (!ld_n_i)        day_q <= preset_i;
    else if (tick_i && over) day_q <= mdays;
    else if (adv_i)          day_q <= (day_q == mdays) ? FIRST : day_q + FIRST;
  end

  AST_DAY_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (ld_n_i && tick_i && day_q > mdays) |=> day_q == $past(mdays)); // R9
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ld_n_i && adv_i && day_q == mdays) |=> day_q == FIRST); // R4
  AST_DAY_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ld_n_i |=> day_q == $past(preset_i)); // R7
endmodule

// File: rtl/cal_chain.sv
module cal_chain
  import cal_pkg::*;
#(
  parameter int SW = SEC_W,
  parameter int HW = HOUR_W,
  parameter int DW = DAY_W,
  parameter int MW = MON_W,
  parameter int YW = YEAR_W,
  parameter int WW = WDAY_W,
  parameter int NF = NFIELD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [NF-1:0] ld_n_i,
  input  logic [SW-1:0] sec_pre_i,
  input  logic [SW-1:0] min_pre_i,
  input  logic [HW-1:0] hour_pre_i,
  input  logic [DW-1:0] day_pre_i,
  input  logic [MW-1:0] mon_pre_i,
  input  logic [YW-1:0] year_pre_i,
  input  logic [WW-1:0] wday_pre_i,
  output logic [SW-1:0] sec_o,
  output logic [SW-1:0] min_o,
  output logic [HW-1:0] hour_o,
  output logic [DW-1:0] day_o,
  output logic [MW-1:0] mon_o,
  output logic [YW-1:0] year_o,
  output logic [WW-1:0] wday_o,
  output logic [DW-1:0] mdays_o
);
  localparam int N60 = 2;

  logic [SW-1:0]  b60_pre [N60];
  logic [SW-1:0]  b60_q   [N60];
  logic [N60-1:0] b60_adv;
  logic [N60-1:0] b60_cy;
  logic           hour_cy, day_cy, mon_cy, year_cy, wday_cy;

  assign b60_pre[0] = sec_pre_i;
  assign b60_pre[1] = min_pre_i;
  assign b60_adv    = {b60_cy[0], tick_i};

  // seconds and minutes share one base-60 stage shape
  for (genvar g = 0; g < N60; g++) begin : g_b60
    cal_wrap_ctr #(.W(SW), .LO(0), .HI(59)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (b60_adv[g]),
      .ld_n_i  (ld_n_i[F_SEC + g]),
      .preset_i(b60_pre[g]),
      .cnt_o   (b60_q[g]),
      .carry_o (b60_cy[g])
    );
  end

  cal_wrap_ctr #(.W(HW), .LO(0), .HI(23)) u_hour (
    .clk(clk), .rst(rst), .adv_i(b60_cy[N60-1]), .ld_n_i(ld_n_i[F_HOUR]),
    .preset_i(hour_pre_i), .cnt_o(hour_o), .carry_o(hour_cy)
  );

  cal_day_ctr #(.DAY_W(DW), .MON_W(MW), .YEAR_W(YW)) u_day (
    .clk(clk), .rst(rst), .tick_i(tick_i), .adv_i(hour_cy),
    .ld_n_i(ld_n_i[F_DAY]), .preset_i(day_pre_i), .mon_i(mon_o),
    .year_i(year_o), .day_o(day_o), .mdays_o(mdays_o), .carry_o(day_cy)
  );

  cal_wrap_ctr #(.W(MW), .LO(1), .HI(12)) u_mon (
    .clk(clk), .rst(rst), .adv_i(day_cy), .ld_n_i(ld_n_i[F_MON]),
    .preset_i(mon_pre_i), .cnt_o(mon_o), .carry_o(mon_cy)
  );

  cal_wrap_ctr #(.W(YW), .LO(0), .HI(99)) u_year (
    .clk(clk), .rst(rst), .adv_i(mon_cy), .ld_n_i(ld_n_i[F_YEAR]),
    .preset_i(year_pre_i), .cnt_o(year_o), .carry_o(year_cy)
  );

  // weekday runs beside the day stage, off the hour carry
  cal_wrap_ctr #(.W(WW), .LO(1), .HI(7)) u_wday (
    .clk(clk), .rst(rst), .adv_i(hour_cy), .ld_n_i(ld_n_i[F_WDAY]),
    .preset_i(wday_pre_i), .cnt_o(wday_o), .carry_o(wday_cy)
  );

  assign sec_o = b60_q[0];
  assign min_o = b60_q[1];

  AST_MIN_ROLL: assert property (@(posedge clk) disable iff (rst)
    (tick_i && (&ld_n_i) && sec_o >= SW'(59)) |=> min_o != $past(min_o)); // R1
  AST_WDAY_STEP: assert property (@(posedge clk) disable iff (rst)
    (hour_cy && ld_n_i[F_WDAY]) |=> wday_o != $past(wday_o)); // R6
  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> (sec_o == '0 && min_o == '0 && hour_o == '0 && day_o == DW'(1)
             && mon_o == MW'(1) && year_o == '0 && wday_o == WW'(1))); // R10
  AST_NO_YEAR_OUT: assert property (@(posedge clk) disable iff (rst)
    year_cy |=> year_o == '0); // R5
  AST_WDAY_CARRY: assert property (@(posedge clk) disable iff (rst)
    wday_cy |=> wday_o == WW'(1)); // R6
endmodule

// File: tb/sim_cal_chain.sv
module sim_cal_chain;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] ld_n = 7'h7f;
  logic [5:0] ps, pm;
  logic [4:0] ph, pd;
  logic [3:0] pmo;
  logic [6:0] py;
  logic [2:0] pw;
  logic [5:0] s, m;
  logic [4:0] h, d, md;
  logic [3:0] mo;
  logic [6:0] y;
  logic [2:0] w;
  int  runs = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  cal_chain u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .ld_n_i(ld_n),
    .sec_pre_i(ps), .min_pre_i(pm), .hour_pre_i(ph), .day_pre_i(pd),
    .mon_pre_i(pmo), .year_pre_i(py), .wday_pre_i(pw),
    .sec_o(s), .min_o(m), .hour_o(h), .day_o(d), .mon_o(mo),
    .year_o(y), .wday_o(w), .mdays_o(md)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [7:0] nt;
    logic [5:0] s0, m0; logic [4:0] h0, d0; logic [3:0] o0; logic [6:0] y0; logic [2:0] w0;
    logic [5:0] s1, m1; logic [4:0] h1, d1; logic [3:0] o1; logic [6:0] y1; logic [2:0] w1;
    logic [4:0] md;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  8'd1, 6'd0, 6'd0, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 6'd1, 6'd0, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 5'd31}, // R1
    '{4'd1,  8'd1, 6'd59,6'd0, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 6'd0, 6'd1, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 5'd31}, // R1
    '{4'd1,  8'd1, 6'd59,6'd59,5'd0,  5'd5,  4'd3,  7'd1,  3'd2, 6'd0, 6'd0, 5'd1,  5'd5,  4'd3,  7'd1,  3'd2, 5'd31}, // R1
    '{4'd2,  8'd1, 6'd59,6'd59,5'd23, 5'd5,  4'd3,  7'd1,  3'd2, 6'd0, 6'd0, 5'd0,  5'd6,  4'd3,  7'd1,  3'd3, 5'd31}, // R2
    '{4'd4,  8'd1, 6'd59,6'd59,5'd23, 5'd31, 4'd1,  7'd3,  3'd7, 6'd0, 6'd0, 5'd0,  5'd1,  4'd2,  7'd3,  3'd1, 5'd28}, // R4 R6
    '{4'd4,  8'd1, 6'd59,6'd59,5'd23, 5'd28, 4'd2,  7'd3,  3'd4, 6'd0, 6'd0, 5'd0,  5'd1,  4'd3,  7'd3,  3'd5, 5'd31}, // R4
    '{4'd3,  8'd1, 6'd59,6'd59,5'd23, 5'd28, 4'd2,  7'd4,  3'd4, 6'd0, 6'd0, 5'd0,  5'd29, 4'd2,  7'd4,  3'd5, 5'd29}, // R3
    '{4'd4,  8'd1, 6'd59,6'd59,5'd23, 5'd29, 4'd2,  7'd4,  3'd1, 6'd0, 6'd0, 5'd0,  5'd1,  4'd3,  7'd4,  3'd2, 5'd31}, // R4
    '{4'd5,  8'd1, 6'd59,6'd59,5'd23, 5'd31, 4'd12, 7'd99, 3'd6, 6'd0, 6'd0, 5'd0,  5'd1,  4'd1,  7'd0,  3'd7, 5'd31}, // R5
    '{4'd3,  8'd1, 6'd59,6'd59,5'd23, 5'd30, 4'd4,  7'd10, 3'd3, 6'd0, 6'd0, 5'd0,  5'd1,  4'd5,  7'd10, 3'd4, 5'd31}, // R3
    '{4'd3,  8'd1, 6'd59,6'd59,5'd23, 5'd30, 4'd11, 7'd12, 3'd7, 6'd0, 6'd0, 5'd0,  5'd1,  4'd12, 7'd12, 3'd1, 5'd31}, // R3 R6
    '{4'd1,  8'd3, 6'd30,6'd0, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 6'd33,6'd0, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 5'd31}, // R1
    '{4'd1,  8'd3, 6'd58,6'd0, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 6'd1, 6'd1, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 5'd31}, // R1
    '{4'd6,  8'd1, 6'd59,6'd59,5'd23, 5'd30, 4'd6,  7'd0,  3'd7, 6'd0, 6'd0, 5'd0,  5'd1,  4'd7,  7'd0,  3'd1, 5'd31}, // R6
    '{4'd8,  8'd1, 6'd62,6'd5, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 6'd0, 6'd6, 5'd0,  5'd1,  4'd1,  7'd0,  3'd1, 5'd31}, // R8
    '{4'd8,  8'd1, 6'd59,6'd59,5'd27, 5'd10, 4'd8,  7'd5,  3'd2, 6'd0, 6'd0, 5'd0,  5'd11, 4'd8,  7'd5,  3'd3, 5'd31}, // R8
    '{4'd9,  8'd1, 6'd0, 6'd0, 5'd10, 5'd31, 4'd2,  7'd5,  3'd2, 6'd1, 6'd0, 5'd10, 5'd28, 4'd2,  7'd5,  3'd2, 5'd28}, // R9
    '{4'd9,  8'd1, 6'd0, 6'd0, 5'd10, 5'd30, 4'd2,  7'd8,  3'd2, 6'd1, 6'd0, 5'd10, 5'd29, 4'd2,  7'd8,  3'd2, 5'd29}, // R9
    '{4'd8,  8'd1, 6'd59,6'd59,5'd23, 5'd31, 4'd13, 7'd20, 3'd1, 6'd0, 6'd0, 5'd0,  5'd1,  4'd1,  7'd21, 3'd2, 5'd31}, // R8 R3
    '{4'd11, 8'd0, 6'd56,6'd34,5'd12, 5'd15, 4'd9,  7'd42, 3'd5, 6'd56,6'd34,5'd12, 5'd15, 4'd9,  7'd42, 3'd5, 5'd30}  // R11
  };

  function automatic logic [40:0] state();
    return {s, m, h, d, mo, y, w, md};
  endfunction

  task automatic check(input string req, input logic [40:0] exp);
    runs++;
    if (state() !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, state(), exp);
    end
  endtask

  task automatic load_all(input logic [5:0] a, input logic [5:0] b, input logic [4:0] c,
                          input logic [4:0] e, input logic [3:0] f, input logic [6:0] g,
                          input logic [2:0] k);
    @(negedge clk);
    ps = a; pm = b; ph = c; pd = e; pmo = f; py = g; pw = k; ld_n = 7'h00;
    @(negedge clk);
    ld_n = 7'h7f;
  endtask

  task automatic one_tick(input logic [6:0] ldv);
    @(negedge clk);
    tick = 1'b1; ld_n = ldv;
    @(negedge clk);
    tick = 1'b0; ld_n = 7'h7f;
    @(negedge clk);
  endtask

  initial begin
    ps = '0; pm = '0; ph = '0; pd = 5'd1; pmo = 4'd1; py = '0; pw = 3'd1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset", {6'd0, 6'd0, 5'd0, 5'd1, 4'd1, 7'd0, 3'd1, 5'd31});

    for (int i = 0; i < NV; i++) begin
      load_all(VEC[i].s0, VEC[i].m0, VEC[i].h0, VEC[i].d0, VEC[i].o0, VEC[i].y0, VEC[i].w0);
      for (int t = 0; t < int'(VEC[i].nt); t++) one_tick(7'h7f);
      repeat (3) @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i].req, i),
            {VEC[i].s1, VEC[i].m1, VEC[i].h1, VEC[i].d1, VEC[i].o1, VEC[i].y1, VEC[i].w1, VEC[i].md});
    end

    // R7: a seconds load on a tick that would roll the minute
    load_all(6'd59, 6'd0, 5'd0, 5'd1, 4'd1, 7'd0, 3'd1);
    ps = 6'd10;
    one_tick(7'h7e);
    check("R7 load beats advance", {6'd10, 6'd0, 5'd0, 5'd1, 4'd1, 7'd0, 3'd1, 5'd31});
    one_tick(7'h7f);
    check("R7 count resumes", {6'd11, 6'd0, 5'd0, 5'd1, 4'd1, 7'd0, 3'd1, 5'd31});

    // R7 R6: a day load on the tick that wraps the hour; weekday still steps
    load_all(6'd59, 6'd59, 5'd23, 5'd5, 4'd3, 7'd1, 3'd2);
    pd = 5'd20;
    one_tick(7'h77);
    check("R7 R6 day load at hour wrap", {6'd0, 6'd0, 5'd0, 5'd20, 4'd3, 7'd1, 3'd3, 5'd31});

    // R9: a clamp on a tick does not advance the month
    load_all(6'd59, 6'd59, 5'd23, 5'd31, 4'd4, 7'd2, 3'd1);
    one_tick(7'h7f);
    check("R9 clamp at hour wrap", {6'd0, 6'd0, 5'd0, 5'd30, 4'd4, 7'd2, 3'd2, 5'd30});

    // R10: reset in the middle of a run
    load_all(6'd12, 6'd13, 5'd14, 5'd15, 4'd6, 7'd50, 3'd4);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R10 mid-run reset", {6'd0, 6'd0, 5'd0, 5'd1, 4'd1, 7'd0, 3'd1, 5'd31});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule